// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a hardware master that runs one SPI flash housekeeping command on request and handles all the chip-select framing itself. It supports four commands: reading the status register, writing the status register, erasing a 4 KB sector, and reading the two-byte identifier. The block drives chip select, hands one byte at a time to an external byte-wide shifter, and reads back the byte the shifter received in the same slot. It makes no assumptions about how fast the shifter runs.

A host picks a command, sets up the address and the status value, and pulses `start_i`. The block then issues every frame the command needs. It raises chip select for a guard gap before each frame. When the command ends, it stores the results and pulses `done_o`. An erase is not finished when its frame ends. The block keeps polling the status register until the flash reports it is no longer busy, and only then signals completion.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, `cs_n_o` is high, `busy_o`, `done_o` and `spi_tx_valid_o` are low, and `status_o` and `id_o` are zero.
- R2: Command code 0 (read status) sends one chip-select frame of three bytes: the read-status opcode (default 0x05), then 0x00, then 0x00. `status_o` takes the byte received in the third slot.
- R3: Command code 1 (write status) sends two frames. The first is the status-unlock opcode (default 0x50) followed by 0x00. The second is the write-status opcode (default 0x01) followed by the value `wr_status_i` had when the command was accepted. `status_o` is not changed.
- R4: Command code 2 (sector erase) sends a frame holding only the write-enable opcode (default 0x06). It then sends a frame with the erase opcode (default 0x20) and the three address bytes, bits 23:16 first and bits 7:0 last.
- R5: After the erase frame, the block repeats read-status frames in the R2 format for as long as bit 0 (busy) of the received status is 1. Each poll updates `status_o`. Completion follows the first poll whose bit 0 is 0.
- R6: Command code 3 (read identifier) sends one six-byte frame: the identifier opcode (default 0x90) followed by five 0x00 bytes. `id_o` becomes the fifth received byte in bits 15:8 and the sixth in bits 7:0. `status_o` is not changed.
- R7: Before every frame, `cs_n_o` is high for at least `GAP_CYCLES` clock cycles.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running command's frames are unchanged, and no further frame follows its completion.
- R9: `done_o` is high for exactly one cycle per command, in the first cycle after the last frame in which `busy_o` is low.
- R10: Each `spi_tx_valid_o` pulse lasts one cycle while `cs_n_o` is low. No further pulse occurs until `spi_byte_done_i` has returned the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for the selected command |
| cmd_i | input | 2 | Command: 0 read status, 1 write status, 2 sector erase, 3 read identifier |
| addr_i | input | ADDR_W | Sector address for an erase |
| wr_status_i | input | 8 | Value to write into the status register |
| spi_tx_o | output | 8 | Byte handed to the shifter |
| spi_tx_valid_o | output | 1 | One-cycle request to shift `spi_tx_o` |
| spi_rx_i | input | 8 | Byte received by the shifter |
| spi_byte_done_i | input | 1 | Shifter finished a byte; `spi_rx_i` is valid |
| cs_n_o | output | 1 | Flash chip select, active low |
| status_o | output | 8 | Last status byte read (bit 0 busy) |
| id_o | output | 16 | Identifier, manufacturer high byte, device low byte |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is an erase that stays busy through several polls while a second start arrives mid-command. The flash model in the bench is set, before each command, to answer a chosen number of polls (0 to 5) with the busy bit set. The bench pulses a conflicting start while the first guard gap is still running. It then checks the whole frame list, including the exact poll count, and also checks that nothing runs after completion. The shifter model varies its byte latency at random, which moves each captured byte relative to the gaps.

// File: rtl/spi_flash_seq_pkg.sv
package spi_flash_seq_pkg;

   typedef enum logic [1:0] {
      CMD_RD_STAT  = 2'd0,
      CMD_WR_STAT  = 2'd1,
      CMD_ERASE    = 2'd2,
      CMD_RD_IDENT = 2'd3
   } cmd_e;

   typedef enum logic [2:0] {
      FR_WR_EN,
      FR_RD_STAT,
      FR_UNLOCK,
      FR_WR_STAT,
      FR_ERASE,
      FR_RD_IDENT
   } frame_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_GAP,
      ST_ISSUE,
      ST_WAIT
   } state_e;

   function automatic frame_e first_frame(input cmd_e c);
      case (c)
         CMD_RD_STAT: return FR_RD_STAT;
         CMD_WR_STAT: return FR_UNLOCK;
         CMD_ERASE:   return FR_WR_EN;
         default:     return FR_RD_IDENT;
      endcase
   endfunction

endpackage

// File: rtl/sfcs_gap_timer.sv
module sfcs_gap_timer #(
   parameter int GAP_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic expired_o
);
   generate
      if (GAP_CYCLES == 1) begin : g_single
         logic unused_in;
         assign unused_in = clk_i ^ rst_ni ^ load_i;
         assign expired_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(GAP_CYCLES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                cnt_q <= '0;
            else if (load_i)            cnt_q <= CW'(GAP_CYCLES - 1);
            else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
         end
         assign expired_o = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/sfcs_frame_rom.sv
module sfcs_frame_rom
   import spi_flash_seq_pkg::*;
#(
   parameter int          ADDR_W         = 24,
   parameter int          SLOT_W         = 3,
   parameter logic [7:0]  OP_WR_EN       = 8'h06,
   parameter logic [7:0]  OP_RD_STAT     = 8'h05,
   parameter logic [7:0]  OP_STAT_UNLOCK = 8'h50,
   parameter logic [7:0]  OP_WR_STAT     = 8'h01,
   parameter logic [7:0]  OP_SECT_ERASE  = 8'h20,
   parameter logic [7:0]  OP_RD_IDENT    = 8'h90
) (
   input  frame_e              frame_i,
   input  logic [SLOT_W-1:0]   slot_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [7:0]          wdata_i,
   output logic [7:0]          byte_o,
   output logic                last_o
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam logic [SLOT_W-1:0] LAST_ERASE = SLOT_W'(ADDR_BYTES);
   localparam logic [SLOT_W-1:0] LAST_IDENT = SLOT_W'(ADDR_BYTES + 2);

   logic [7:0] addr_byte [ADDR_BYTES];
   logic [7:0] addr_sel;

   // most significant address byte goes out first
   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
      assign addr_byte[g] = addr_i[(ADDR_BYTES-1-g)*8 +: 8];
   end

   always_comb begin
      addr_sel = 8'h00;
      for (int k = 0; k < ADDR_BYTES; k++)
         if (slot_i == SLOT_W'(k + 1)) addr_sel = addr_byte[k];
   end

   always_comb begin
      byte_o = 8'h00;
      last_o = 1'b0;
      case (frame_i)
         FR_WR_EN: begin
            byte_o = OP_WR_EN;
            last_o = 1'b1;
         end
         FR_RD_STAT: begin
            byte_o = (slot_i == '0) ? OP_RD_STAT : 8'h00;
            last_o = (slot_i == SLOT_W'(2));
         end
         FR_UNLOCK: begin
            byte_o = (slot_i == '0) ? OP_STAT_UNLOCK : 8'h00;
            last_o = (slot_i == SLOT_W'(1));
         end
         FR_WR_STAT: begin
            byte_o = (slot_i == '0) ? OP_WR_STAT : wdata_i;
            last_o = (slot_i == SLOT_W'(1));
         end
         FR_ERASE: begin
            byte_o = (slot_i == '0) ? OP_SECT_ERASE : addr_sel;
            last_o = (slot_i == LAST_ERASE);
         end
         FR_RD_IDENT: begin
            byte_o = (slot_i == '0) ? OP_RD_IDENT : 8'h00;
            last_o = (slot_i == LAST_IDENT);
         end
         default: begin
            byte_o = 8'h00;
            last_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/sfcs_plan.sv
module sfcs_plan
   import spi_flash_seq_pkg::*;
(
   input  cmd_e    cmd_i,
   input  frame_e  frame_i,
   input  logic    flash_busy_i,
   output frame_e  frame_next_o,
   output logic    finish_o
);
   always_comb begin
      frame_next_o = frame_i;
      finish_o     = 1'b1;
      case (frame_i)
         FR_WR_EN: begin
            frame_next_o = FR_ERASE;
            finish_o     = 1'b0;
         end
         FR_ERASE: begin
            frame_next_o = FR_RD_STAT;
            finish_o     = 1'b0;
         end
         FR_UNLOCK: begin
            frame_next_o = FR_WR_STAT;
            finish_o     = 1'b0;
         end
         FR_RD_STAT: begin
            // erase keeps polling while the flash reports busy
            finish_o = !(cmd_i == CMD_ERASE && flash_busy_i);
         end
         default: finish_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/spi_flash_cmd_seq.sv
module spi_flash_cmd_seq
   import spi_flash_seq_pkg::*;
#(
   parameter int          ADDR_W         = 24,
   parameter int          GAP_CYCLES     = 16,
   parameter logic [7:0]  OP_WR_EN       = 8'h06,
   parameter logic [7:0]  OP_RD_STAT     = 8'h05,
   parameter logic [7:0]  OP_STAT_UNLOCK = 8'h50,
   parameter logic [7:0]  OP_WR_STAT     = 8'h01,
   parameter logic [7:0]  OP_SECT_ERASE  = 8'h20,
   parameter logic [7:0]  OP_RD_IDENT    = 8'h90
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [1:0]        cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wr_status_i,
   output logic [7:0]        spi_tx_o,
   output logic              spi_tx_valid_o,
   input  logic [7:0]        spi_rx_i,
   input  logic              spi_byte_done_i,
   output logic              cs_n_o,
   output logic [7:0]        status_o,
   output logic [15:0]       id_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int SLOT_W     = $clog2(ADDR_BYTES + 3);
   localparam logic [SLOT_W-1:0] STAT_SLOT   = SLOT_W'(2);
   localparam logic [SLOT_W-1:0] ID_HI_SLOT  = SLOT_W'(ADDR_BYTES + 1);
   localparam logic [SLOT_W-1:0] ID_LO_SLOT  = SLOT_W'(ADDR_BYTES + 2);
   localparam int HW = $clog2(GAP_CYCLES + 2);

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be a positive multiple of 8");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
   endgenerate

   state_e              state_q;
   cmd_e                cmd_q;
   frame_e              frame_q, frame_next;
   logic [SLOT_W-1:0]   slot_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [7:0]          wdata_q;
   logic [7:0]          status_q;
   logic [15:0]         id_q;
   logic                done_q;
   logic                slot_last, finish, gap_expired, gap_load, byte_in;

   assign byte_in  = (state_q == ST_WAIT) && spi_byte_done_i;
   assign gap_load = ((state_q == ST_IDLE) && start_i) ||
                     (byte_in && slot_last && !finish);

   sfcs_frame_rom #(
      .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
      .OP_WR_EN(OP_WR_EN), .OP_RD_STAT(OP_RD_STAT),
      .OP_STAT_UNLOCK(OP_STAT_UNLOCK), .OP_WR_STAT(OP_WR_STAT),
      .OP_SECT_ERASE(OP_SECT_ERASE), .OP_RD_IDENT(OP_RD_IDENT)
   ) u_rom (
      .frame_i(frame_q), .slot_i(slot_q), .addr_i(addr_q),
      .wdata_i(wdata_q), .byte_o(spi_tx_o), .last_o(slot_last)
   );

   sfcs_plan u_plan (
      .cmd_i(cmd_q), .frame_i(frame_q), .flash_busy_i(spi_rx_i[0]),
      .frame_next_o(frame_next), .finish_o(finish)
   );

   sfcs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(gap_load), .expired_o(gap_expired)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         cmd_q    <= CMD_RD_STAT;
         frame_q  <= FR_RD_STAT;
         slot_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         status_q <= '0;
         id_q     <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               cmd_q   <= cmd_e'(cmd_i);
               frame_q <= first_frame(cmd_e'(cmd_i));
               addr_q  <= addr_i;
               wdata_q <= wr_status_i;
               slot_q  <= '0;
               state_q <= ST_GAP;
            end
            ST_GAP:   if (gap_expired) state_q <= ST_ISSUE;
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: if (spi_byte_done_i) begin
               if (frame_q == FR_RD_STAT && slot_q == STAT_SLOT) status_q <= spi_rx_i;
               if (frame_q == FR_RD_IDENT && slot_q == ID_HI_SLOT) id_q[15:8] <= spi_rx_i;
               if (frame_q == FR_RD_IDENT && slot_q == ID_LO_SLOT) id_q[7:0]  <= spi_rx_i;
               if (slot_last) begin
                  slot_q <= '0;
                  if (finish) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     frame_q <= frame_next;
                     state_q <= ST_GAP;
                  end
               end else begin
                  slot_q  <= slot_q + 1'b1;
                  state_q <= ST_ISSUE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_tx_valid_o = (state_q == ST_ISSUE);
   assign cs_n_o         = !((state_q == ST_ISSUE) || (state_q == ST_WAIT));
   assign busy_o         = (state_q != ST_IDLE);
   assign done_o         = done_q;
   assign status_o       = status_q;
   assign id_o           = id_q;

   // cycles chip select has been high, saturating; used by the gap check
   logic [HW-1:0] cs_hi_cnt;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cs_hi_cnt <= '0;
      else if (!cs_n_o)                       cs_hi_cnt <= '0;
      else if (cs_hi_cnt < HW'(GAP_CYCLES))   cs_hi_cnt <= cs_hi_cnt + 1'b1;
   end

   p_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cs_n_o) |-> cs_hi_cnt >= HW'(GAP_CYCLES));

   p_tx_then_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spi_tx_valid_o |=> (!spi_tx_valid_o && state_q == ST_WAIT));

   p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && cs_n_o));

   p_erase_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && cmd_q == CMD_ERASE) |-> !status_o[0]);

   p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(wdata_q)));
endmodule

// File: tb/tb_spi_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_spi_flash_cmd_seq;
   localparam int GAP = 16;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cmd = '0;
   logic [23:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  tx;
   logic        tx_valid;
   logic [7:0]  rx = '0;
   logic        byte_done = 1'b0;
   logic        cs_n, busy, done;
   logic [7:0]  status;
   logic [15:0] id;

   always #2.5 clk = ~clk;

   spi_flash_cmd_seq #(.GAP_CYCLES(GAP)) dut (
      .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .cmd_i(cmd),
      .addr_i(addr), .wr_status_i(wdata), .spi_tx_o(tx),
      .spi_tx_valid_o(tx_valid), .spi_rx_i(rx), .spi_byte_done_i(byte_done),
      .cs_n_o(cs_n), .status_o(status), .id_o(id), .busy_o(busy), .done_o(done)
   );

   int n_checks = 0;
   int n_errs   = 0;

   task automatic chk(input bit ok, input string req, input string what);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   // flash and shifter model
   logic [7:0] fr_b [16][8];
   int         fr_len [16];
   int         fr_n = 0;
   int         cur_slot = 0;
   bit         prev_cs = 1'b1;
   int         hi_cnt = 0;
   int         min_gap = 1000000;
   int         lat_cnt = 0;
   int         inflight_viol = 0;
   logic [7:0] m_status = 8'h00;
   int         m_polls = 0;
   int         erase_polls_cfg = 0;
   logic [7:0] m_mfg = 8'hBF;
   logic [7:0] m_dev = 8'h41;

   always @(negedge clk) begin
      byte_done = 1'b0;
      if (lat_cnt > 0) begin
         lat_cnt--;
         if (lat_cnt == 0) byte_done = 1'b1;
      end
      if (rst_ni) begin
         if (!cs_n && prev_cs) begin
            if (hi_cnt < min_gap) min_gap = hi_cnt;
            cur_slot = 0;
         end
         if (tx_valid) begin
            if (cs_n || lat_cnt > 0 || byte_done) inflight_viol++;
            if (fr_n < 16 && cur_slot < 8) fr_b[fr_n][cur_slot] = tx;
            if (cur_slot == 2 && fr_b[fr_n][0] == 8'h05)
               rx = (m_polls > 0) ? (m_status | 8'h01) : m_status;
            else if (cur_slot == 4 && fr_b[fr_n][0] == 8'h90) rx = m_mfg;
            else if (cur_slot == 5 && fr_b[fr_n][0] == 8'h90) rx = m_dev;
            else rx = 8'($urandom);
            cur_slot++;
            lat_cnt = 1 + int'($urandom % 4);
         end
         if (cs_n && !prev_cs && fr_n < 16) begin
            fr_len[fr_n] = cur_slot;
            if (fr_b[fr_n][0] == 8'h05 && m_polls > 0) m_polls--;
            if (fr_b[fr_n][0] == 8'h01 && cur_slot == 2) m_status = {fr_b[fr_n][1][7:1], 1'b0};
            if (fr_b[fr_n][0] == 8'h20 && cur_slot == 4) m_polls = erase_polls_cfg;
            fr_n++;
         end
         hi_cnt  = cs_n ? hi_cnt + 1 : 0;
         prev_cs = cs_n;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   logic [7:0]  exp_status = 8'h00;
   logic [15:0] exp_id = 16'h0000;

   task automatic run_cmd(input int c, input logic [23:0] a, input logic [7:0] w,
                          input int polls, input bit poke);
      logic [7:0] eb [16][8];
      int         el [16];
      int         en;
      int         guard;
      bit         same;
      string      req;
      en = 0;
      case (c)
         0: begin eb[0][0]=8'h05; eb[0][1]=8'h00; eb[0][2]=8'h00; el[0]=3; en=1; req="R2"; end
         1: begin
            eb[0][0]=8'h50; eb[0][1]=8'h00; el[0]=2;
            eb[1][0]=8'h01; eb[1][1]=w;     el[1]=2; en=2; req="R3";
         end
         2: begin
            eb[0][0]=8'h06; el[0]=1;
            eb[1][0]=8'h20; eb[1][1]=a[23:16]; eb[1][2]=a[15:8]; eb[1][3]=a[7:0]; el[1]=4;
            en = 2;
            for (int p = 0; p <= polls; p++) begin
               eb[en][0]=8'h05; eb[en][1]=8'h00; eb[en][2]=8'h00; el[en]=3; en++;
            end
            req = "R4";
         end
         default: begin
            eb[0][0]=8'h90;
            for (int k = 1; k < 6; k++) eb[0][k] = 8'h00;
            el[0]=6; en=1; req="R6";
         end
      endcase
      if (c == 0) exp_status = m_status;
      if (c == 2) exp_status = {m_status[7:1], 1'b0};
      if (c == 3) exp_id = {m_mfg, m_dev};
      erase_polls_cfg = polls;
      fr_n = 0;
      cmd = 2'(c); addr = a; wdata = w; start = 1'b1;
      tick();
      start = 1'b0;
      if (poke) begin
         repeat (3) tick();
         cmd = 2'(c + 1); addr = ~a; wdata = ~w; start = 1'b1;
         tick();
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 20000) begin tick(); guard++; end
      chk(done, "R9", $sformatf("no done pulse, actual %0d expected 1", done));
      chk(!busy, "R9", $sformatf("busy with done, actual %0d expected 0", busy));
      chk(fr_n == en, (c == 2) ? "R5" : req,
          $sformatf("cmd %0d frame count actual %0d expected %0d", c, fr_n, en));
      same = 1'b1;
      for (int f = 0; f < en && f < fr_n; f++) begin
         if (fr_len[f] != el[f]) same = 1'b0;
         for (int k = 0; k < el[f] && k < 8; k++)
            if (fr_b[f][k] !== eb[f][k]) begin
               same = 1'b0;
               $display("  frame %0d byte %0d actual %02h expected %02h", f, k, fr_b[f][k], eb[f][k]);
            end
      end
      chk(same, req, $sformatf("cmd %0d frame contents differ (see lines above)", c));
      chk(status == exp_status, (c == 2) ? "R5" : ((c == 0) ? "R2" : "R3"),
          $sformatf("status actual %02h expected %02h", status, exp_status));
      chk(id == exp_id, "R6", $sformatf("id actual %04h expected %04h", id, exp_id));
      tick();
      chk(!done, "R9", $sformatf("done width, actual %0d expected 0", done));
      if (poke) begin
         repeat (40) tick();
         chk(!busy && fr_n == en, "R8",
             $sformatf("after ignored start busy %0d frames %0d expected 0/%0d", busy, fr_n, en));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4242);
      repeat (3) tick();
      chk(cs_n && !busy && !done && !tx_valid, "R1",
          $sformatf("in reset cs_n %0d busy %0d done %0d tx %0d expected 1 0 0 0",
                    cs_n, busy, done, tx_valid));
      rst_ni = 1'b1;
      tick();
      chk(status == 8'h00 && id == 16'h0000, "R1",
          $sformatf("after reset status %02h id %04h expected 00 0000", status, id));

      // directed corner cases
      m_status = 8'h3C;
      run_cmd(0, 24'h0, 8'h00, 0, 1'b0);
      run_cmd(1, 24'h0, 8'h9D, 0, 1'b0);
      run_cmd(0, 24'h0, 8'h00, 0, 1'b0);
      run_cmd(2, 24'hA1B2C3, 8'h00, 0, 1'b0);
      run_cmd(2, 24'h00F000, 8'h00, 5, 1'b1);
      run_cmd(3, 24'h0, 8'h00, 0, 1'b1);

      // random mix
      for (int i = 0; i < 24; i++) begin
         int c;
         c = int'($urandom % 4);
         m_status = 8'($urandom) & 8'hFE;
         m_mfg = 8'($urandom);
         m_dev = 8'($urandom);
         run_cmd(c, 24'($urandom), 8'($urandom), int'($urandom % 6), ($urandom % 3) == 0);
      end

      chk(min_gap >= GAP, "R7", $sformatf("shortest gap actual %0d expected >= %0d", min_gap, GAP));
      chk(inflight_viol == 0, "R10",
          $sformatf("byte requests with cs high or byte in flight actual %0d expected 0", inflight_viol));
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule